// File: doc/BRIEF.md
# Standby-Rail Low-Voltage Supervisor

This block sits inside a hardware-monitor chip that keeps running from a standby supply while the host processor's core rail is lowered or switched off in sleep states. It takes a comparator flag that reports the core-voltage reading is under its programmed low limit. It filters that flag against a periodic sample strobe. It then turns the filtered condition into a sticky status bit and an alert request. When the feature is enabled by a control bit, it also puts the chip's thermal machinery into a safe hold.

While the hold is active, the thermal-event timer keeps its value: it neither counts nor clears. Writes that adapt the minimum-temperature setting are discarded. A new entry into the shutdown state is refused. When the rail recovers, the hold releases. The timer then continues from the value it held, and adaptation and shutdown entry work again. With the feature disabled, a low rail still reaches the status bit and the alert request, but nothing is held.

Top module: `lvsup_top`

## Requirements
- R1: The filtered low-voltage state (1 = low) changes only after `vcore_low` has differed from it at `DEB_STROBES` (default 2) consecutive clocks with `sample_stb` high. A single differing strobe followed by a matching one has no effect.
- R2: `lv_status` goes to 1 one clock after the filtered state becomes low. This happens whether or not `lv_feat_en` is set.
- R3: `lv_status` is sticky. It returns to 0 only on a clock where `status_rdclr` is 1 and the filtered state is not low; while the filtered state is low, setting wins over the read-clear.
- R4: `alert_req` is 1 exactly when `lv_status` is 1 and `alert_en` is 1.
- R5: `lv_inhibit` is a registered hold-enable. It is 1 one clock after the filtered state is low while `lv_feat_en` is 1, and it is 0 in all other cases.
- R6: While `lv_inhibit` is 1, `tmr_value` is frozen. `therm_active` does not advance it and `therm_clr` does not clear it.
- R7: While `lv_inhibit` is 0, `tmr_value` increments on each clock with `therm_active` high. It saturates at 2^`TMR_W`-1 and goes to 0 on `therm_clr`. After a hold it resumes from the held value.
- R8: A `tmin_wr` pulse loads `tmin_wdata` into `tmin_value` on the next clock edge only when `lv_inhibit` is 0. While the hold is active the write is discarded.
- R9: `shutdown_active` can turn on from `shutdown_req` only while `lv_inhibit` is 0. Once on, it stays on while `shutdown_req` is held, even during a hold, and it turns off on the clock after `shutdown_req` drops.
- R10: After reset, `lv_status`, `alert_req`, `lv_inhibit`, `tmr_value` and `shutdown_active` are 0, and `tmin_value` equals `TMIN_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | Comparator sample strobe |
| vcore_low | input | 1 | Core voltage below low limit (raw comparator flag) |
| lv_feat_en | input | 1 | Enables the hold behaviour on low voltage |
| alert_en | input | 1 | Alert enable |
| status_rdclr | input | 1 | Host read-clear strobe for the status bit |
| therm_active | input | 1 | Thermal-event condition; advances the timer |
| therm_clr | input | 1 | Thermal timer clear request |
| tmin_wr | input | 1 | Minimum-temperature adaptation write |
| tmin_wdata | input | TMIN_W | New minimum-temperature value |
| shutdown_req | input | 1 | Request to enter shutdown |
| lv_status | output | 1 | Sticky low-voltage status bit |
| alert_req | output | 1 | Alert request |
| lv_inhibit | output | 1 | Hold-enable for timer, adaptation and shutdown |
| tmr_value | output | TMR_W | Thermal-event timer value |
| tmin_value | output | TMIN_W | Current minimum-temperature value |
| shutdown_active | output | 1 | Shutdown state |

## Verification
The hardest states to reach from the ports combine the hold with existing state. One is a timer that already has a count and must keep it through a hold. Another is a shutdown that was entered before the rail dropped and must be kept, not refused. To reach these, the stimulus first builds up timer counts and enters shutdown with the rail good. It then walks the comparator flag through two strobes to enter the hold and hits every frozen input during it. Finally it releases the hold and checks that counting resumes from the held value. The read-clear race is reached by pulsing the read-clear while the filtered state is still low. The debounce is tested by a single-strobe glitch inside a low episode.

// File: rtl/lvsup_pkg.sv
package lvsup_pkg;

   typedef enum logic {
      RAIL_GOOD = 1'b0,
      RAIL_LOW  = 1'b1
   } rail_state_e;

   typedef struct packed {
      logic hold_en;
      logic alert_en;
   } lvsup_ctrl_t;

   function automatic int unsigned deb_cnt_width(input int unsigned strobes);
      return (strobes < 3) ? 1 : $clog2(strobes);
   endfunction

endpackage

// File: rtl/lvsup_debounce.sv
module lvsup_debounce
   import lvsup_pkg::*;
#(
   parameter int unsigned DEB_STROBES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sample_stb,
   input  logic        raw_low,
   output rail_state_e filt_state
);
   localparam int unsigned CW = deb_cnt_width(DEB_STROBES);

   generate
      if (DEB_STROBES < 1) begin : g_bad
         $error("lvsup_debounce: DEB_STROBES must be at least 1");
      end else if (DEB_STROBES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_state <= RAIL_GOOD;
            end else if (sample_stb) begin
               filt_state <= rail_state_e'(raw_low);
            end
         end
      end else begin : g_count
         logic [CW-1:0] agree_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_state <= RAIL_GOOD;
               agree_cnt  <= '0;
            end else if (sample_stb) begin
               if (raw_low != logic'(filt_state)) begin
                  if (agree_cnt == CW'(DEB_STROBES - 1)) begin
                     filt_state <= rail_state_e'(raw_low);
                     agree_cnt  <= '0;
                  end else begin
                     agree_cnt <= agree_cnt + 1'b1;
                  end
               end else begin
                  agree_cnt <= '0;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lvsup_therm_timer.sv
module lvsup_therm_timer #(
   parameter int unsigned TMR_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             count_en,
   input  logic             clr,
   output logic [TMR_W-1:0] value
);
   localparam logic [TMR_W-1:0] MAX_VAL = {TMR_W{1'b1}};

   logic [TMR_W-1:0] inc_val;

   generate
      if (TMR_W < 2) begin : g_bad
         $error("lvsup_therm_timer: TMR_W must be at least 2");
      end
      if (SATURATE) begin : g_sat
         assign inc_val = (value == MAX_VAL) ? value : value + 1'b1;
      end else begin : g_wrap
         assign inc_val = value + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (!hold) begin
         if (clr) begin
            value <= '0;
         end else if (count_en) begin
            value <= inc_val;
         end
      end
   end
endmodule

// File: rtl/lvsup_guard.sv
module lvsup_guard #(
   parameter int unsigned       TMIN_W   = 8,
   parameter logic [TMIN_W-1:0] TMIN_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inhibit,
   input  logic              tmin_wr,
   input  logic [TMIN_W-1:0] tmin_wdata,
   input  logic              sdn_req,
   output logic [TMIN_W-1:0] tmin_value,
   output logic              sdn_active
);
   logic sdn_next;

   generate
      if (TMIN_W < 1) begin : g_bad
         $error("lvsup_guard: TMIN_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmin_value <= TMIN_RST;
      end else if (tmin_wr && !inhibit) begin
         tmin_value <= tmin_wdata;
      end
   end

   // an existing shutdown is kept; only a new entry is refused
   always_comb begin
      sdn_next = sdn_req && (sdn_active || !inhibit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdn_active <= 1'b0;
      end else begin
         sdn_active <= sdn_next;
      end
   end
endmodule

// File: rtl/lvsup_top.sv
module lvsup_top
   import lvsup_pkg::*;
#(
   parameter int unsigned       DEB_STROBES  = 2,
   parameter int unsigned       TMR_W        = 16,
   parameter bit                TMR_SATURATE = 1'b1,
   parameter int unsigned       TMIN_W       = 8,
   parameter logic [TMIN_W-1:0] TMIN_RST     = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   input  logic              vcore_low,
   input  logic              lv_feat_en,
   input  logic              alert_en,
   input  logic              status_rdclr,
   input  logic              therm_active,
   input  logic              therm_clr,
   input  logic              tmin_wr,
   input  logic [TMIN_W-1:0] tmin_wdata,
   input  logic              shutdown_req,
   output logic              lv_status,
   output logic              alert_req,
   output logic              lv_inhibit,
   output logic [TMR_W-1:0]  tmr_value,
   output logic [TMIN_W-1:0] tmin_value,
   output logic              shutdown_active
);
   rail_state_e filt_state;
   logic        filt_low;
   lvsup_ctrl_t ctrl;

   assign ctrl.hold_en  = lv_feat_en;
   assign ctrl.alert_en = alert_en;
   assign filt_low      = (filt_state == RAIL_LOW);

   lvsup_debounce #(
      .DEB_STROBES (DEB_STROBES)
   ) u_deb (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .raw_low    (vcore_low),
      .filt_state (filt_state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lv_status  <= 1'b0;
         lv_inhibit <= 1'b0;
      end else begin
         lv_status  <= (lv_status && !status_rdclr) || filt_low;
         lv_inhibit <= filt_low && ctrl.hold_en;
      end
   end

   assign alert_req = lv_status && ctrl.alert_en;

   lvsup_therm_timer #(
      .TMR_W    (TMR_W),
      .SATURATE (TMR_SATURATE)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (lv_inhibit),
      .count_en (therm_active),
      .clr      (therm_clr),
      .value    (tmr_value)
   );

   lvsup_guard #(
      .TMIN_W   (TMIN_W),
      .TMIN_RST (TMIN_RST)
   ) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .inhibit    (lv_inhibit),
      .tmin_wr    (tmin_wr),
      .tmin_wdata (tmin_wdata),
      .sdn_req    (shutdown_req),
      .tmin_value (tmin_value),
      .sdn_active (shutdown_active)
   );
endmodule

// File: rtl/lvsup_chk.sv
module lvsup_chk #(
   parameter int unsigned TMR_W  = 16,
   parameter int unsigned TMIN_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_stb,
   input logic              vcore_low,
   input logic              lv_feat_en,
   input logic              status_rdclr,
   input logic              filt_low,
   input logic              lv_status,
   input logic              alert_req,
   input logic              lv_inhibit,
   input logic [TMR_W-1:0]  tmr_value,
   input logic [TMIN_W-1:0] tmin_value,
   input logic              shutdown_active
);
   p_filter_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(filt_low) |-> ($past(sample_stb) && $past(vcore_low)));

   p_status_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      filt_low |=> lv_status);

   p_status_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lv_status) |-> ($past(status_rdclr) && !$past(filt_low)));

   p_alert_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      alert_req |-> lv_status);

   p_hold_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lv_inhibit |-> ($past(filt_low) && $past(lv_feat_en)));

   p_tmr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lv_inhibit |=> $stable(tmr_value));

   p_tmin_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lv_inhibit |=> $stable(tmin_value));

   p_no_sdn_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lv_inhibit && !shutdown_active) |=> !shutdown_active);
endmodule

bind lvsup_top lvsup_chk #(
   .TMR_W  (TMR_W),
   .TMIN_W (TMIN_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .sample_stb      (sample_stb),
   .vcore_low       (vcore_low),
   .lv_feat_en      (lv_feat_en),
   .status_rdclr    (status_rdclr),
   .filt_low        (filt_low),
   .lv_status       (lv_status),
   .alert_req       (alert_req),
   .lv_inhibit      (lv_inhibit),
   .tmr_value       (tmr_value),
   .tmin_value      (tmin_value),
   .shutdown_active (shutdown_active)
);

// File: tb/lvsup_top_tb.sv
module lvsup_top_tb;
   localparam int          CLK_PERIOD = 10;
   localparam int          TMR_W      = 4;
   localparam int          TMIN_W     = 8;
   localparam logic [7:0]  TMIN_RST   = 8'h5A;
   localparam int          NVEC       = 14;

   // {vcore_low, feat_en, alert_en, rdclr, exp_inhibit, exp_status, exp_alert}
   localparam logic [6:0] VEC [NVEC] = '{
      7'b1110_000,  // first low strobe: no change (R1)
      7'b1110_111,  // second low strobe: status, inhibit, alert (R1 R2 R5 R4)
      7'b0110_111,  // one-strobe glitch high: ignored (R1)
      7'b1110_111,  // agrees again, counter restarts
      7'b0100_110,  // alerts off: alert drops (R4)
      7'b0100_010,  // recovered: inhibit off, status sticky (R3 R5)
      7'b0111_000,  // read-clear after recovery (R3)
      7'b1010_000,  // feature off, first strobe
      7'b1010_011,  // feature off: status and alert, no inhibit (R2 R5)
      7'b1011_011,  // read-clear while low: set wins (R3)
      7'b1110_111,  // feature on while low: inhibit (R5)
      7'b0110_111,  // first recover strobe
      7'b0110_011,  // recovered
      7'b0111_000   // cleared (R3)
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sample_stb = 1'b0;
   logic              vcore_low = 1'b0;
   logic              lv_feat_en = 1'b0;
   logic              alert_en = 1'b0;
   logic              status_rdclr = 1'b0;
   logic              therm_active = 1'b0;
   logic              therm_clr = 1'b0;
   logic              tmin_wr = 1'b0;
   logic [TMIN_W-1:0] tmin_wdata = '0;
   logic              shutdown_req = 1'b0;
   logic              lv_status;
   logic              alert_req;
   logic              lv_inhibit;
   logic [TMR_W-1:0]  tmr_value;
   logic [TMIN_W-1:0] tmin_value;
   logic              shutdown_active;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvsup_top #(
      .DEB_STROBES (2),
      .TMR_W       (TMR_W),
      .TMIN_W      (TMIN_W),
      .TMIN_RST    (TMIN_RST)
   ) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .sample_stb      (sample_stb),
      .vcore_low       (vcore_low),
      .lv_feat_en      (lv_feat_en),
      .alert_en        (alert_en),
      .status_rdclr    (status_rdclr),
      .therm_active    (therm_active),
      .therm_clr       (therm_clr),
      .tmin_wr         (tmin_wr),
      .tmin_wdata      (tmin_wdata),
      .shutdown_req    (shutdown_req),
      .lv_status       (lv_status),
      .alert_req       (alert_req),
      .lv_inhibit      (lv_inhibit),
      .tmr_value       (tmr_value),
      .tmin_value      (tmin_value),
      .shutdown_active (shutdown_active)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one strobe with optional read-clear, then one more edge; ends on a negedge
   task automatic step(input logic v, input logic rc);
      @(negedge clk);
      vcore_low    = v;
      status_rdclr = rc;
      sample_stb   = 1'b1;
      @(negedge clk);
      sample_stb   = 1'b0;
      status_rdclr = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      run(2);
      rst_n = 1'b1;
      run(1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      run(3);
      rst_n = 1'b1;
      run(1);
      // R10 reset state
      chk("R10 status", lv_status, 0);
      chk("R10 alert", alert_req, 0);
      chk("R10 inhibit", lv_inhibit, 0);
      chk("R10 timer", tmr_value, 0);
      chk("R10 tmin", tmin_value, TMIN_RST);
      chk("R10 shutdown", shutdown_active, 0);

      for (int i = 0; i < NVEC; i++) begin
         lv_feat_en = VEC[i][5];
         alert_en   = VEC[i][4];
         step(VEC[i][6], VEC[i][3]);
         chk($sformatf("R5 vec%0d inhibit", i), lv_inhibit, VEC[i][2]);
         chk($sformatf("R3 vec%0d status", i), lv_status, VEC[i][1]);
         chk($sformatf("R4 vec%0d alert", i), alert_req, VEC[i][0]);
      end

      do_reset();
      lv_feat_en = 1'b1;
      therm_active = 1'b1; run(5); therm_active = 1'b0;
      chk("R7 count", tmr_value, 5);
      tmin_wr = 1'b1; tmin_wdata = 8'h33; run(1); tmin_wr = 1'b0;
      chk("R8 write accepted", tmin_value, 8'h33);

      step(1'b1, 1'b0); step(1'b1, 1'b0);
      chk("R5 hold on", lv_inhibit, 1);
      therm_active = 1'b1; run(4); therm_active = 1'b0;
      chk("R6 no count", tmr_value, 5);
      therm_clr = 1'b1; run(1); therm_clr = 1'b0;
      chk("R6 no clear", tmr_value, 5);
      tmin_wr = 1'b1; tmin_wdata = 8'h77; run(1); tmin_wr = 1'b0; run(1);
      chk("R8 write discarded", tmin_value, 8'h33);
      shutdown_req = 1'b1; run(2);
      chk("R9 entry refused", shutdown_active, 0);
      shutdown_req = 1'b0;

      step(1'b0, 1'b0); step(1'b0, 1'b0);
      chk("R5 hold off", lv_inhibit, 0);
      therm_active = 1'b1; run(3); therm_active = 1'b0;
      chk("R7 resume", tmr_value, 8);
      therm_clr = 1'b1; run(1); therm_clr = 1'b0;
      chk("R7 clear", tmr_value, 0);
      therm_active = 1'b1; run(20); therm_active = 1'b0;
      chk("R7 saturate", tmr_value, 15);

      shutdown_req = 1'b1; run(1);
      chk("R9 entry", shutdown_active, 1);
      step(1'b1, 1'b0); step(1'b1, 1'b0);
      chk("R9 hold active", lv_inhibit, 1);
      chk("R9 kept during hold", shutdown_active, 1);
      shutdown_req = 1'b0; run(1);
      chk("R9 exit", shutdown_active, 0);
      shutdown_req = 1'b1; run(2);
      chk("R9 re-entry refused", shutdown_active, 0);
      shutdown_req = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule